// File: doc/BRIEF.md
# DDR Command Timing Checker

This block watches the command bus of a DDR SDRAM with four banks and reports the first command that breaks the protocol. On every rising clock edge it reads clock enable, chip select, the three strobe lines, the two bank-address bits and address bit 10, and decodes one command. It tracks whether each bank is open or closed. It also keeps saturating counters of the cycles since each timing-relevant event, both per bank and across the device.

Each command is tested against the bank-state rules and the minimum command spacings. The block also raises an error when a bank stays open too long with no command at all. The first violation latches an error code and a bank number. These stay put until a synchronous clear. Every limit is set in picoseconds and turned into clock cycles by ceiling division with the clock period. The one exception is the open-time maximum, which uses floor division. The block can sit beside a memory controller as a protocol watchdog, or inside a testbench as a scoreboard for a controller model.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: After reset, errFlag is 0, errCode is 0 and errBank is 0, all banks count as closed and every spacing counts as already met.
- R2: With csN low and cke high, {rasN,casN,weN} decodes as: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop, 111 NOP. csN high is deselect. A read or write to a closed bank gives code 1. An activate to an open bank gives code 2.
- R3: A read or write less than 2 cycles after the activate of its bank gives code 3 (default 15 ns at 7.5 ns period). Column commands on consecutive cycles are legal.
- R4: A precharge of an open bank less than 6 cycles after its activate gives code 4.
- R5: A bank still open 13334 cycles after its activate gives code 5 on that cycle with no command needed. A precharge at exactly 13333 cycles is legal.
- R6: An activate less than 9 cycles after the previous activate of the same bank gives code 6. This check takes priority over R7.
- R7: An activate less than 3 cycles after its bank was closed gives code 7.
- R8: An activate less than 2 cycles after an activate to any bank gives code 8.
- R9: A precharge less than 2 cycles after the last write to that bank gives code 9.
- R10: Any command other than NOP or deselect less than 2 cycles after a mode-register set gives code 10, with errBank taken from ba. This check takes priority over all others.
- R11: A refresh or mode-register set while any bank is open gives code 11, with errBank set to the lowest open bank.
- R12: A precharge with a10 high closes and checks every open bank, lowest violating bank reported. A read or write with a10 high closes its bank, and that close starts the R7 spacing.
- R13: While cke is low the bus is ignored, and only the R5 timeout can raise an error.
- R14: errFlag, errCode and errBank hold the first violation until a cycle with clrErr high. If a new violation arrives in the same cycle as the clear, it is captured. Results appear one cycle after the command is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the bus |
| rstN | input | 1 | Synchronous active-low reset |
| clrErr | input | 1 | Synchronous clear of the latched error |
| cke | input | 1 | Clock enable; low makes the bus ignored |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | All-banks / auto-precharge option bit |
| errFlag | output | 1 | A violation has been latched |
| errCode | output | 4 | Code of the latched violation |
| errBank | output | 2 | Bank of the latched violation |

## Verification
Two actions can meet in one cycle: a synchronous clear of the latched error and a new violation. The bench drives this case directly by raising the clear while issuing a read to a closed bank. The expected result is that the flag stays high and the new bank number replaces the old one. It also checks the opposite case, where a clear with a legal command drops the flag on the next cycle.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_COL_IDLE = 4'd1,
    ERR_ACT_OPEN = 4'd2,
    ERR_RCD      = 4'd3,
    ERR_RAS_MIN  = 4'd4,
    ERR_RAS_MAX  = 4'd5,
    ERR_RC       = 4'd6,
    ERR_RP       = 4'd7,
    ERR_RRD      = 4'd8,
    ERR_WR       = 4'd9,
    ERR_MRD      = 4'd10,
    ERR_NOT_IDLE = 4'd11
  } err_e;

  // Strobes from the rule evaluator to the state/counter datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] act;
    logic [NUM_BANKS-1:0] close;
    logic [NUM_BANKS-1:0] wr;
    logic                 mrs;
    logic                 viol;
    err_e                 code;
    logic [BANK_W-1:0]    bank;
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ddr_chk_ctrl.sv
module ddr_chk_ctrl
  import ddr_chk_pkg::*;
#(
  parameter int AGE_W       = 14,
  parameter int RCD_CYC     = 2,
  parameter int RAS_MIN_CYC = 6,
  parameter int RAS_MAX_CYC = 13333,
  parameter int RC_CYC      = 9,
  parameter int RP_CYC      = 3,
  parameter int RRD_CYC     = 2,
  parameter int WR_CYC      = 2,
  parameter int MRD_CYC     = 2
) (
  input  logic                            cke,
  input  logic                            csN,
  input  logic                            rasN,
  input  logic                            casN,
  input  logic                            weN,
  input  logic [BANK_W-1:0]               ba,
  input  logic                            a10,
  input  logic [NUM_BANKS-1:0]            bankOpen,
  input  logic [NUM_BANKS-1:0][AGE_W-1:0] actAge,
  input  logic [NUM_BANKS-1:0][AGE_W-1:0] preAge,
  input  logic [NUM_BANKS-1:0][AGE_W-1:0] wrAge,
  input  logic [AGE_W-1:0]                rrdAge,
  input  logic [AGE_W-1:0]                mrsAge,
  output strobe_t                         strb
);

  localparam logic [AGE_W-1:0] RCD_L     = AGE_W'(RCD_CYC);
  localparam logic [AGE_W-1:0] RAS_MIN_L = AGE_W'(RAS_MIN_CYC);
  localparam logic [AGE_W-1:0] RAS_MAX_L = AGE_W'(RAS_MAX_CYC);
  localparam logic [AGE_W-1:0] RC_L      = AGE_W'(RC_CYC);
  localparam logic [AGE_W-1:0] RP_L      = AGE_W'(RP_CYC);
  localparam logic [AGE_W-1:0] RRD_L     = AGE_W'(RRD_CYC);
  localparam logic [AGE_W-1:0] WR_L      = AGE_W'(WR_CYC);
  localparam logic [AGE_W-1:0] MRD_L     = AGE_W'(MRD_CYC);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] baHot;
  logic [NUM_BANKS-1:0] preSel;

  always_comb begin
    cmd = CMD_NONE;
    if (cke && !csN) begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NONE;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      baHot[b]  = (ba == BANK_W'(b));
      preSel[b] = a10 || baHot[b];
    end
  end

  always_comb begin
    strb      = '0;
    strb.code = ERR_NONE;
    // state strobes: applied whether or not the command was legal
    for (int b = 0; b < NUM_BANKS; b++) begin
      strb.act[b]   = (cmd == CMD_ACT) && baHot[b];
      strb.wr[b]    = (cmd == CMD_WR) && baHot[b];
      strb.close[b] = bankOpen[b] &&
                      (((cmd == CMD_PRE) && preSel[b]) ||
                       (((cmd == CMD_RD) || (cmd == CMD_WR)) && a10 && baHot[b]));
    end
    strb.mrs = (cmd == CMD_MRS);

    // rule evaluation, first match wins
    if ((cmd != CMD_NONE) && (mrsAge < MRD_L)) begin
      strb.viol = 1'b1; strb.code = ERR_MRD; strb.bank = ba;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (bankOpen[ba]) begin
            strb.viol = 1'b1; strb.code = ERR_ACT_OPEN; strb.bank = ba;
          end else if (actAge[ba] < RC_L) begin
            strb.viol = 1'b1; strb.code = ERR_RC; strb.bank = ba;
          end else if (preAge[ba] < RP_L) begin
            strb.viol = 1'b1; strb.code = ERR_RP; strb.bank = ba;
          end else if (rrdAge < RRD_L) begin
            strb.viol = 1'b1; strb.code = ERR_RRD; strb.bank = ba;
          end
        end
        CMD_RD, CMD_WR: begin
          if (!bankOpen[ba]) begin
            strb.viol = 1'b1; strb.code = ERR_COL_IDLE; strb.bank = ba;
          end else if (actAge[ba] < RCD_L) begin
            strb.viol = 1'b1; strb.code = ERR_RCD; strb.bank = ba;
          end
        end
        CMD_PRE: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (!strb.viol && preSel[b] && bankOpen[b]) begin
              if (actAge[b] < RAS_MIN_L) begin
                strb.viol = 1'b1; strb.code = ERR_RAS_MIN; strb.bank = BANK_W'(b);
              end else if (wrAge[b] < WR_L) begin
                strb.viol = 1'b1; strb.code = ERR_WR; strb.bank = BANK_W'(b);
              end
            end
          end
        end
        CMD_REF, CMD_MRS: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (!strb.viol && bankOpen[b]) begin
              strb.viol = 1'b1; strb.code = ERR_NOT_IDLE; strb.bank = BANK_W'(b);
            end
          end
        end
        default: ;
      endcase
    end

    // open-too-long timeout, lowest priority
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!strb.viol && bankOpen[b] && (actAge[b] > RAS_MAX_L)) begin
        strb.viol = 1'b1; strb.code = ERR_RAS_MAX; strb.bank = BANK_W'(b);
      end
    end
  end

endmodule

// File: rtl/ddr_chk_track.sv
module ddr_chk_track
  import ddr_chk_pkg::*;
#(
  parameter int AGE_W       = 14,
  parameter int RAS_MAX_CYC = 13333
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            clrErr,
  input  strobe_t                         strb,
  output logic [NUM_BANKS-1:0]            bankOpen,
  output logic [NUM_BANKS-1:0][AGE_W-1:0] actAge,
  output logic [NUM_BANKS-1:0][AGE_W-1:0] preAge,
  output logic [NUM_BANKS-1:0][AGE_W-1:0] wrAge,
  output logic [AGE_W-1:0]                rrdAge,
  output logic [AGE_W-1:0]                mrsAge,
  output logic                            errFlag,
  output err_e                            errCode,
  output logic [BANK_W-1:0]               errBank
);

  // saturation point: one past the longest limit any rule compares against
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RAS_MAX_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] v);
    return (v == AGE_MAX) ? v : v + AGE_ONE;
  endfunction

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             openQ;
    logic [AGE_W-1:0] actQ, preQ, wrQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        actQ  <= AGE_MAX;
        preQ  <= AGE_MAX;
        wrQ   <= AGE_MAX;
      end else begin
        if (strb.act[g]) begin
          openQ <= 1'b1;
          actQ  <= AGE_ONE;
        end else begin
          actQ  <= bump(actQ);
          if (strb.close[g]) openQ <= 1'b0;
        end
        preQ <= strb.close[g] ? AGE_ONE : bump(preQ);
        wrQ  <= strb.wr[g]    ? AGE_ONE : bump(wrQ);
      end
    end

    assign bankOpen[g] = openQ;
    assign actAge[g]   = actQ;
    assign preAge[g]   = preQ;
    assign wrAge[g]    = wrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdAge <= AGE_MAX;
      mrsAge <= AGE_MAX;
    end else begin
      rrdAge <= (|strb.act) ? AGE_ONE : bump(rrdAge);
      mrsAge <= strb.mrs    ? AGE_ONE : bump(mrsAge);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
      errBank <= '0;
    end else if (strb.viol && (!errFlag || clrErr)) begin
      errFlag <= 1'b1;
      errCode <= strb.code;
      errBank <= strb.bank;
    end else if (clrErr) begin
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
      errBank <= '0;
    end
  end

endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
  import ddr_chk_pkg::*;
#(
  parameter int CLK_PS       = 7500,
  parameter int T_RCD_PS     = 15000,
  parameter int T_RAS_MIN_PS = 45000,
  parameter int T_RAS_MAX_PS = 100000000,
  parameter int T_RC_PS      = 65000,
  parameter int T_RP_PS      = 20000,
  parameter int T_RRD_PS     = 15000,
  parameter int T_WR_PS      = 15000,
  parameter int T_MRD_PS     = 15000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrErr,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic       errFlag,
  output logic [3:0] errCode,
  output logic [1:0] errBank
);

  localparam int RCD_CYC     = ceilDiv(T_RCD_PS, CLK_PS);
  localparam int RAS_MIN_CYC = ceilDiv(T_RAS_MIN_PS, CLK_PS);
  localparam int RAS_MAX_CYC = T_RAS_MAX_PS / CLK_PS;
  localparam int RC_CYC      = ceilDiv(T_RC_PS, CLK_PS);
  localparam int RP_CYC      = ceilDiv(T_RP_PS, CLK_PS);
  localparam int RRD_CYC     = ceilDiv(T_RRD_PS, CLK_PS);
  localparam int WR_CYC      = ceilDiv(T_WR_PS, CLK_PS);
  localparam int MRD_CYC     = ceilDiv(T_MRD_PS, CLK_PS);
  localparam int AGE_W       = $clog2(RAS_MAX_CYC + 2);

  strobe_t                         strb;
  logic [NUM_BANKS-1:0]            bankOpen;
  logic [NUM_BANKS-1:0][AGE_W-1:0] actAge, preAge, wrAge;
  logic [AGE_W-1:0]                rrdAge, mrsAge;
  err_e                            errCodeQ;

  ddr_chk_ctrl #(
    .AGE_W(AGE_W), .RCD_CYC(RCD_CYC), .RAS_MIN_CYC(RAS_MIN_CYC),
    .RAS_MAX_CYC(RAS_MAX_CYC), .RC_CYC(RC_CYC), .RP_CYC(RP_CYC),
    .RRD_CYC(RRD_CYC), .WR_CYC(WR_CYC), .MRD_CYC(MRD_CYC)
  ) i_ctrl (
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .a10(a10), .bankOpen(bankOpen), .actAge(actAge),
    .preAge(preAge), .wrAge(wrAge), .rrdAge(rrdAge), .mrsAge(mrsAge),
    .strb(strb)
  );

  ddr_chk_track #(
    .AGE_W(AGE_W), .RAS_MAX_CYC(RAS_MAX_CYC)
  ) i_track (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .strb(strb),
    .bankOpen(bankOpen), .actAge(actAge), .preAge(preAge), .wrAge(wrAge),
    .rrdAge(rrdAge), .mrsAge(mrsAge), .errFlag(errFlag),
    .errCode(errCodeQ), .errBank(errBank)
  );

  assign errCode = errCodeQ;

endmodule

// File: rtl/ddr_chk_sva.sv
module ddr_chk_sva (
  input logic       clk,
  input logic       rstN,
  input logic       clrErr,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       errFlag,
  input logic [3:0] errCode,
  input logic [1:0] errBank,
  input logic       newViol
);

  // R1: a clear flag carries a zero code and bank
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> (errCode == 4'd0) && (errBank == 2'd0));

  // R14: latched error holds while no clear is given
  a_r14_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !clrErr |=> errFlag && $stable(errCode) && $stable(errBank));

  // R14: a clear without a fresh violation drops the flag
  a_r14_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrErr && !newViol |=> !errFlag);

  // R14: a violation while clear is captured
  a_r14_capture: assert property (@(posedge clk) disable iff (!rstN)
    newViol && !errFlag |=> errFlag);

  // R13: with cke low only the open-time timeout may appear
  a_r13_cke_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cke && !errFlag && !clrErr |=> !errFlag || (errCode == 4'd5));

  // R2: an open-bank activate error follows an activate on the bus
  a_r2_act_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) && (errCode == 4'd2) |->
      $past(cke && !csN && !rasN && casN && weN));

  // R3: a row-to-column error follows a column command on the bus
  a_r3_rcd_col: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) && (errCode == 4'd3) |->
      $past(cke && !csN && rasN && !casN));

endmodule

bind ddr_cmd_timing_chk ddr_chk_sva i_sva (
  .clk(clk), .rstN(rstN), .clrErr(clrErr), .cke(cke), .csN(csN),
  .rasN(rasN), .casN(casN), .weN(weN), .errFlag(errFlag),
  .errCode(errCode), .errBank(errBank), .newViol(strb.viol)
);

// File: tb/test_ddr_cmd_timing_chk.sv
module test_ddr_cmd_timing_chk;

  localparam logic [3:0] OP_ACT = 4'b0011;
  localparam logic [3:0] OP_RD  = 4'b0101;
  localparam logic [3:0] OP_WR  = 4'b0100;
  localparam logic [3:0] OP_PRE = 4'b0010;
  localparam logic [3:0] OP_REF = 4'b0001;
  localparam logic [3:0] OP_MRS = 4'b0000;
  localparam logic [3:0] OP_NOP = 4'b0111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clrErr = 1'b0;
  logic       cke = 1'b1;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       errFlag;
  logic [3:0] errCode;
  logic [1:0] errBank;

  always #2 clk = ~clk;

  ddr_cmd_timing_chk i_ddr_cmd_timing_chk (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .a10(a10),
    .errFlag(errFlag), .errCode(errCode), .errBank(errBank)
  );

  typedef struct {
    logic       f;
    logic [3:0] c;
    logic [1:0] b;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         compared = 0;
  int         mismatched = 0;
  logic       expF = 1'b0;
  logic [3:0] expC = 4'd0;
  logic [1:0] expB = 2'd0;

  // monitor: compares outputs after each posedge against queued items
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (errFlag !== e.f || errCode !== e.c || errBank !== e.b) begin
          mismatched++;
          $display("FAIL %s: got flag=%0b code=%0d bank=%0d, expected flag=%0b code=%0d bank=%0d",
                   e.tag, errFlag, errCode, errBank, e.f, e.c, e.b);
        end
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] b, input logic ad,
                       input logic ck, input logic clr, input int ec, input int eb,
                       input string tag);
    @(negedge clk);
    {csN, rasN, casN, weN} = op;
    ba = b; a10 = ad; cke = ck; clrErr = clr;
    @(posedge clk);
    if (clr) begin expF = 1'b0; expC = 4'd0; expB = 2'd0; end
    if (ec != 0 && (!expF || clr)) begin
      expF = 1'b1; expC = 4'(ec); expB = 2'(eb);
    end
    q.push_back('{expF, expC, expB, tag});
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(OP_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 0, 0, tag);
  endtask

  task automatic restart();
    @(negedge clk);
    rstN = 1'b0; {csN, rasN, casN, weN} = OP_NOP; cke = 1'b1; clrErr = 1'b0; a10 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expF = 1'b0; expC = 4'd0; expB = 2'd0;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    restart();
    issue(OP_NOP, 0, 0, 1, 0, 0, 0, "R1 reset state");

    // R3: spacing met, back-to-back column commands, then too early
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R3 act");
    nops(1, "R3");
    issue(OP_RD, 0, 0, 1, 0, 0, 0, "R3 read at limit");
    issue(OP_RD, 0, 0, 1, 0, 0, 0, "R3 consecutive read");
    issue(OP_WR, 0, 0, 1, 0, 0, 0, "R3 consecutive write");
    restart();
    issue(OP_ACT, 1, 0, 1, 0, 0, 0, "R3 act");
    issue(OP_RD, 1, 0, 1, 0, 3, 1, "R3 read too early");

    // R2: closed-bank read, open-bank activate
    restart();
    issue(OP_RD, 2, 0, 1, 0, 1, 2, "R2 read closed bank");
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R2 act");
    nops(2, "R2");
    issue(OP_ACT, 0, 0, 1, 0, 2, 0, "R2 act open bank");

    // R4
    restart();
    issue(OP_ACT, 3, 0, 1, 0, 0, 0, "R4 act");
    nops(4, "R4");
    issue(OP_PRE, 3, 0, 1, 0, 4, 3, "R4 early precharge");

    // R6 and R7
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R6 act");
    nops(5, "R6");
    issue(OP_PRE, 0, 0, 1, 0, 0, 0, "R6 precharge");
    nops(1, "R6");
    issue(OP_ACT, 0, 0, 1, 0, 6, 0, "R6 reactivate early");
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R7 act");
    nops(6, "R7");
    issue(OP_PRE, 0, 0, 1, 0, 0, 0, "R7 precharge");
    nops(1, "R7");
    issue(OP_ACT, 0, 0, 1, 0, 7, 0, "R7 activate after short close");
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R6 act");
    nops(5, "R6");
    issue(OP_PRE, 0, 0, 1, 0, 0, 0, "R6 precharge");
    nops(2, "R7");
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R6 R7 both limits met");

    // R8
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R8 act");
    issue(OP_ACT, 1, 0, 1, 0, 8, 1, "R8 other bank too soon");
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R8 act");
    nops(1, "R8");
    issue(OP_ACT, 2, 0, 1, 0, 0, 0, "R8 other bank at limit");

    // R9
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R9 act");
    nops(4, "R9");
    issue(OP_WR, 0, 0, 1, 0, 0, 0, "R9 write");
    issue(OP_PRE, 0, 0, 1, 0, 9, 0, "R9 precharge after write");

    // R10
    restart();
    issue(OP_MRS, 0, 0, 1, 0, 0, 0, "R10 mode set");
    issue(OP_ACT, 0, 0, 1, 0, 10, 0, "R10 command too soon");
    restart();
    issue(OP_MRS, 1, 0, 1, 0, 0, 0, "R10 ext mode set");
    nops(1, "R10");
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R10 command at limit");

    // R11
    restart();
    issue(OP_ACT, 2, 0, 1, 0, 0, 0, "R11 act");
    nops(2, "R11");
    issue(OP_REF, 0, 0, 1, 0, 11, 2, "R11 refresh with open bank");

    // R12 precharge-all and auto-precharge
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R12 act b0");
    nops(1, "R12");
    issue(OP_ACT, 1, 0, 1, 0, 0, 0, "R12 act b1");
    nops(5, "R12");
    issue(OP_PRE, 0, 1, 1, 0, 0, 0, "R12 precharge all");
    issue(OP_RD, 1, 0, 1, 0, 1, 1, "R12 bank closed by all");
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R12 act b0");
    nops(1, "R12");
    issue(OP_ACT, 1, 0, 1, 0, 0, 0, "R12 act b1");
    nops(3, "R12");
    issue(OP_PRE, 0, 1, 1, 0, 4, 1, "R12 all with young bank");
    restart();
    issue(OP_ACT, 3, 0, 1, 0, 0, 0, "R12 act b3");
    nops(1, "R12");
    issue(OP_RD, 3, 1, 1, 0, 0, 0, "R12 read auto-precharge");
    nops(6, "R12");
    issue(OP_ACT, 3, 0, 1, 0, 0, 0, "R12 reopen after auto close");
    nops(1, "R12");
    issue(OP_RD, 3, 0, 1, 0, 0, 0, "R12 read reopened");
    restart();
    issue(OP_ACT, 3, 0, 1, 0, 0, 0, "R12 act b3");
    nops(1, "R12");
    issue(OP_WR, 3, 1, 1, 0, 0, 0, "R12 write auto-precharge");
    issue(OP_RD, 3, 0, 1, 0, 1, 3, "R12 bank closed by auto");

    // R13
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R13 act");
    issue(OP_ACT, 0, 0, 0, 0, 0, 0, "R13 ignored activate");
    issue(OP_RD, 2, 0, 0, 0, 0, 0, "R13 ignored read");
    issue(OP_NOP, 0, 0, 1, 0, 0, 0, "R13 cke back");
    issue(OP_ACT, 0, 0, 1, 0, 2, 0, "R13 bank still open");

    // R14 sticky and clear
    restart();
    issue(OP_ACT, 0, 0, 1, 0, 0, 0, "R14 act");
    issue(OP_RD, 1, 0, 1, 0, 1, 1, "R14 first violation");
    issue(OP_RD, 2, 0, 1, 0, 1, 2, "R14 second held off");
    issue(OP_NOP, 0, 0, 1, 1, 0, 0, "R14 clear");
    issue(OP_NOP, 0, 0, 1, 0, 0, 0, "R14 stays clear");
    issue(OP_RD, 1, 0, 1, 0, 1, 1, "R14 new violation");
    issue(OP_RD, 3, 0, 1, 1, 1, 3, "R14 clear with violation");
    issue(OP_NOP, 0, 0, 1, 1, 0, 0, "R14 final clear");

    // R5 open-time limit
    restart();
    issue(OP_ACT, 1, 0, 1, 0, 0, 0, "R5 act");
    nops(13332, "R5 waiting");
    issue(OP_PRE, 1, 0, 1, 0, 0, 0, "R5 precharge at max");
    restart();
    issue(OP_ACT, 1, 0, 1, 0, 0, 0, "R5 act");
    nops(13333, "R5 waiting");
    issue(OP_NOP, 0, 0, 1, 0, 5, 1, "R5 timeout");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule